// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one 256-byte page of processor memory into a 256-byte sprite attribute store. The processor starts a copy by pulsing a trigger strobe with a byte of data. That byte becomes the upper half of the 16-bit source address. The engine then issues one read per cycle at source offsets 0x00 up to 0xFF. It writes each returned byte into the sprite store at a running 8-bit destination pointer. The pointer wraps inside the store.

While the copy runs, the engine holds a stall output high for a fixed count. The count is 513 cycles when the trigger lands on an even processor cycle and 514 when it lands on an odd one. The parity comes from an input sampled together with the trigger. A one-cycle done pulse marks the end of the stall. The destination pointer is the sprite-address register. Software can load it while the engine is idle, and it keeps whatever value the copy leaves in it.

Top module: `spr_dma_top`

## Requirements
- R1: A trigger strobe while idle latches trigData as the source page. Starting the cycle after the trigger, rdEn is high for exactly 256 consecutive cycles, and rdAddr = {page, offset} with the offset counting 0x00 to 0xFF in ascending order.
- R2: Read data is valid one cycle after each rdEn cycle. In that cycle sprWrEn is high and sprWrData equals rdData.
- R3: Each sprite write goes to sprWrAddr = the destination pointer (ptr), which then increments modulo 256. The pointer keeps its value after the copy, so a copy that starts at any value ends at that same value.
- R4: stall goes high the cycle after an accepted trigger. It stays high for 513 cycles if oddCycle was 0 at the trigger, and for 514 cycles if oddCycle was 1.
- R5: done is high for exactly one cycle: the first cycle in which stall is low again after a copy.
- R6: A trigger strobe while stall is high is ignored. The source page, the read sequence and the stall length of the running copy are unchanged.
- R7: ptrWr loads ptrWrData into the pointer on the next cycle while idle. It is ignored while stall is high.
- R8: After reset, stall, done, rdEn and sprWrEn are 0 and ptr is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigStrobe | input | 1 | Start request (trigger register write) |
| trigData | input | 8 | Source page byte |
| oddCycle | input | 1 | Parity of the current processor cycle (1 = odd) |
| ptrWr | input | 1 | Write to the destination pointer |
| ptrWrData | input | 8 | Value for the destination pointer |
| rdEn | output | 1 | Source read request |
| rdAddr | output | 16 | Source read address |
| rdData | input | 8 | Read data, valid one cycle after rdEn |
| sprWrEn | output | 1 | Sprite store write enable |
| sprWrAddr | output | 8 | Sprite store write address |
| sprWrData | output | 8 | Sprite store write data |
| ptr | output | 8 | Current destination pointer |
| stall | output | 1 | Processor stall |
| done | output | 1 | End-of-stall pulse |

## Verification
A wrong offset counter shows at once on rdAddr, in the first read cycle after the trigger, and a copy that stops early or late shows in its last few cycles. A slip in the pointer shows on sprWrAddr at the very next write, and again at the end as a pointer that does not return to its start value. Any error in the stall counter, including a wrong parity choice, remains hidden for about 513 cycles. It appears only at the falling edge of stall and at the timing of the done pulse.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic start;  // accept trigger: latch page, clear offset
    logic rdGo;   // issue a source read this cycle
  } dmaCtl_t;
endpackage

// File: rtl/spr_dma_ctrl.sv
module spr_dma_ctrl
  import spr_dma_pkg::*;
#(
  parameter int STALL_EVEN = 513,
  parameter int STALL_ODD  = 514,
  localparam int CNT_W = $clog2(STALL_ODD + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    trigStrobe,
  input  logic    oddCycle,
  input  logic    lastRead,
  output dmaCtl_t ctl,
  output logic    stall,
  output logic    done
);
  logic [CNT_W-1:0] stallCnt;
  logic             reading;
  logic             startNow;

  localparam logic [CNT_W-1:0] LOAD_EVEN = CNT_W'(STALL_EVEN);
  localparam logic [CNT_W-1:0] LOAD_ODD  = CNT_W'(STALL_ODD);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  assign stall    = (stallCnt != '0);
  assign startNow = trigStrobe & ~stall;

  always_comb begin
    ctl.start = startNow;
    ctl.rdGo  = reading;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stallCnt <= '0;
      reading  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (stallCnt == CNT_ONE);
      if (startNow) begin
        stallCnt <= oddCycle ? LOAD_ODD : LOAD_EVEN;
        reading  <= 1'b1;
      end else begin
        if (stall) stallCnt <= stallCnt - CNT_ONE;
        if (reading && lastRead) reading <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spr_dma_datapath.sv
module spr_dma_datapath
  import spr_dma_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int SPR_AW = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PAGE_W + SPR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmaCtl_t           ctl,
  input  logic              busy,
  input  logic [PAGE_W-1:0] trigData,
  input  logic              ptrWr,
  input  logic [SPR_AW-1:0] ptrWrData,
  input  logic [DATA_W-1:0] rdData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sprWrEn,
  output logic [SPR_AW-1:0] sprWrAddr,
  output logic [DATA_W-1:0] sprWrData,
  output logic [SPR_AW-1:0] ptr,
  output logic              lastRead
);
  logic [PAGE_W-1:0] page;
  logic [SPR_AW-1:0] offset;
  logic [SPR_AW-1:0] dstPtr;
  logic              wrPend;

  assign rdEn      = ctl.rdGo;
  assign rdAddr    = {page, offset};
  assign lastRead  = (offset == '1);
  assign sprWrEn   = wrPend;
  assign sprWrAddr = dstPtr;
  assign sprWrData = rdData;
  assign ptr       = dstPtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page   <= '0;
      offset <= '0;
      dstPtr <= '0;
      wrPend <= 1'b0;
    end else begin
      wrPend <= ctl.rdGo;
      if (ctl.start) begin
        page   <= trigData;
        offset <= '0;
      end else if (ctl.rdGo) begin
        offset <= offset + 1'b1;
      end
      if (wrPend)
        dstPtr <= dstPtr + 1'b1;
      else if (ptrWr && !busy)
        dstPtr <= ptrWrData;
    end
  end
endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top
  import spr_dma_pkg::*;
#(
  parameter int STALL_EVEN = 513,
  parameter int STALL_ODD  = 514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trigStrobe,
  input  logic [7:0]  trigData,
  input  logic        oddCycle,
  input  logic        ptrWr,
  input  logic [7:0]  ptrWrData,
  output logic        rdEn,
  output logic [15:0] rdAddr,
  input  logic [7:0]  rdData,
  output logic        sprWrEn,
  output logic [7:0]  sprWrAddr,
  output logic [7:0]  sprWrData,
  output logic [7:0]  ptr,
  output logic        stall,
  output logic        done
);
  dmaCtl_t ctl;
  logic    lastRead;

  spr_dma_ctrl #(.STALL_EVEN(STALL_EVEN), .STALL_ODD(STALL_ODD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigStrobe(trigStrobe), .oddCycle(oddCycle),
    .lastRead(lastRead), .ctl(ctl), .stall(stall), .done(done)
  );

  spr_dma_datapath #(.PAGE_W(8), .SPR_AW(8), .DATA_W(8)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .busy(stall), .trigData(trigData),
    .ptrWr(ptrWr), .ptrWrData(ptrWrData), .rdData(rdData), .rdEn(rdEn),
    .rdAddr(rdAddr), .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr),
    .sprWrData(sprWrData), .ptr(ptr), .lastRead(lastRead)
  );
endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
  parameter int STALL_EVEN = 513,
  parameter int STALL_ODD  = 514
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rdEn,
  input logic       sprWrEn,
  input logic [7:0] sprWrAddr,
  input logic [7:0] ptr,
  input logic       stall,
  input logic       done
);
  int stallRun;

  always_ff @(posedge clk) begin
    if (!rst_n) stallRun <= 0;
    else if (stall) stallRun <= stallRun + 1;
    else stallRun <= 0;
  end

  p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stallRun <= STALL_ODD);

  p_stall_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (stallRun == STALL_EVEN || stallRun == STALL_ODD));

  p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall && $past(stall)));

  p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sprWrEn |-> $past(rdEn));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sprWrEn) |-> (ptr == $past(sprWrAddr) + 8'd1));

  p_read_in_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |-> stall);

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall) && !$past(sprWrEn)) |-> $stable(ptr));
endmodule

bind spr_dma_top spr_dma_chk #(.STALL_EVEN(STALL_EVEN), .STALL_ODD(STALL_ODD)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdEn(rdEn), .sprWrEn(sprWrEn),
  .sprWrAddr(sprWrAddr), .ptr(ptr), .stall(stall), .done(done)
);

// File: tb/sim_spr_dma_top.sv
`timescale 1ns/1ps
module sim_spr_dma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigStrobe = 1'b0;
  logic [7:0]  trigData = '0;
  logic        oddCycle = 1'b0;
  logic        ptrWr = 1'b0;
  logic [7:0]  ptrWrData = '0;
  logic        rdEn, sprWrEn, stall, done;
  logic [15:0] rdAddr;
  logic [7:0]  rdData = '0;
  logic [7:0]  sprWrAddr, sprWrData, ptr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  spr_dma_top u0 (
    .clk(clk), .rst_n(rst_n), .trigStrobe(trigStrobe), .trigData(trigData),
    .oddCycle(oddCycle), .ptrWr(ptrWr), .ptrWrData(ptrWrData), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr),
    .sprWrData(sprWrData), .ptr(ptr), .stall(stall), .done(done)
  );

  function automatic logic [7:0] srcByte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // source memory model: one cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rdEn) rdData <= srcByte(rdAddr);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
  end

  task automatic loadPtr(input logic [7:0] v);
    @(negedge clk); ptrWr = 1'b1; ptrWrData = v;
    @(negedge clk); ptrWr = 1'b0;
    check(ptr == v, "R7 idle load", ptr, v);
  endtask

  // one full copy with monitor; optional retrigger / pointer write mid-run
  task automatic runCopy(input logic [7:0] page, input bit odd,
                         input logic [7:0] startPtr, input bit retrig,
                         input bit midPtrWr);
    int reads = 0, writes = 0, stallCycles = 0, doneCount = 0, doneAt = -1;
    int rdBad = 0, wrBad = 0, gap = 0;
    int k = 0;
    logic [7:0] expPtr;
    bit firstSeen = 0;
    loadPtr(startPtr);
    expPtr = startPtr;
    @(negedge clk);
    trigStrobe = 1'b1; trigData = page; oddCycle = odd;
    @(negedge clk);
    trigStrobe = 1'b0; oddCycle = ~odd;
    check(stall && rdEn, "R4 stall starts", int'(stall), 1);
    while (k < 600) begin
      if (k == 40 && retrig) begin trigStrobe = 1'b1; trigData = page ^ 8'hFF; oddCycle = ~odd; end
      if (k == 41) begin trigStrobe = 1'b0; ptrWr = 1'b0; end
      if (k == 40 && midPtrWr) begin ptrWr = 1'b1; ptrWrData = 8'hC3; end
      if (stall) stallCycles++;
      if (done) begin doneCount++; if (doneAt < 0) doneAt = k; end
      if (rdEn) begin
        if (rdAddr != {page, reads[7:0]}) rdBad++;
        if (firstSeen && gap != 0) rdBad++;
        firstSeen = 1; gap = 0;
        reads++;
      end else if (firstSeen && reads < 256) gap++;
      if (sprWrEn) begin
        if (sprWrAddr != expPtr || sprWrData != srcByte({page, writes[7:0]})) wrBad++;
        expPtr = expPtr + 8'd1;
        writes++;
      end
      @(negedge clk);
      k++;
    end
    check(reads == 256, "R1 read count", reads, 256);
    check(rdBad == 0, "R1 read order and page", rdBad, 0);
    check(writes == 256 && wrBad == 0, "R2 write data", wrBad, 0);
    check(ptr == startPtr, "R3 pointer returns to start", ptr, startPtr);
    check(stallCycles == (odd ? 514 : 513), "R4 stall length", stallCycles, odd ? 514 : 513);
    check(doneCount == 1 && doneAt == stallCycles, "R5 done pulse", doneAt, stallCycles);
    if (retrig) check(stallCycles == (odd ? 514 : 513) && rdBad == 0, "R6 retrigger ignored", rdBad, 0);
    if (midPtrWr) check(ptr == startPtr && wrBad == 0, "R7 busy pointer write ignored", ptr, startPtr);
  endtask

  task automatic testReset();
    check(!stall && !done && !rdEn && !sprWrEn, "R8 reset outputs", int'(stall), 0);
    check(ptr == 8'h00, "R8 reset pointer", ptr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runCopy(8'h12, 1'b0, 8'h00, 1'b0, 1'b0);  // R1..R5 even, start 0
    runCopy(8'h3C, 1'b1, 8'h40, 1'b0, 1'b0);  // R3 wrap, R4 odd
    runCopy(8'hA7, 1'b0, 8'hFF, 1'b1, 1'b0);  // R6 retrigger
    runCopy(8'h05, 1'b1, 8'h81, 1'b0, 1'b1);  // R7 pointer write while busy
    summary();
  end
endmodule